// File: doc/BRIEF.md
# Bus Turnaround Timeout Timer

This block guards the quiet gap that a full-speed USB link must keep short between two packet phases that belong together. Examples are a token followed by its data packet, or a data packet followed by its handshake. When the surrounding logic reports an end-of-packet and also says that a follow-on phase is due, the timer arms. It then counts bit times for as long as the line stays idle.

If the line leaves idle first, the timer disarms quietly. If the idle gap runs past the allowed number of bit times, the block emits a one-clock error pulse and disarms. The count advances only on a one-clock bit-time strobe, so the limit is the same at any system clock rate. Line decoding, end-of-packet detection and the choice of which phases need a follow-on are done by the neighbouring logic.

Top module: `bus_turnaround_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the timer disarms, and `timeout_err` is 0 in the cycle after that edge.
- R2: An `eop_seen` pulse together with `follow_expected`=1 arms the timer with a count of zero.
- R3: While armed and `line_idle`=1, the 17th `bit_tick` (one more than the 16 bit-time limit) makes `timeout_err` high for exactly one clock, in the cycle after that tick's edge. The timer then disarms, so further idle ticks give no second pulse.
- R4: While armed, `line_idle`=0 at a clock edge disarms the timer without a pulse. This holds even when the 17th tick falls on that same edge.
- R5: An `eop_seen` pulse with `follow_expected`=0 leaves the timer disarmed and produces no pulse, however many idle ticks follow.
- R6: An `eop_seen` pulse with `follow_expected`=1 while already armed restarts the count from zero.
- R7: Clocks without `bit_tick` do not advance the count. The timeout depends only on the number of strobes.
- R8: A reset during an armed count cancels it, and no pulse follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-clock strobe per bit time |
| eop_seen | input | 1 | One-clock pulse at the end of a packet |
| line_idle | input | 1 | High while the line is in the idle state |
| follow_expected | input | 1 | Qualifies `eop_seen`: a further phase must follow |
| timeout_err | output | 1 | One-clock turnaround timeout pulse |

## Verification
The stimulus covers several idle gaps:
- 17 back-to-back ticks, which must time out.
- 16 ticks followed by activity, which must not.
- Activity that arrives on the same edge as the 17th tick. This separates the cancel-first priority from tick-first behaviour.
- Ticks spaced several clocks apart. These show that the count follows the strobe and not the clock.

Further patterns are a re-armed end-of-packet partway through a gap, which distinguishes a restart from a count that carries on, and an end-of-packet with no follow-on expected. A reset partway through a count and a long idle stretch after a timeout show that the timer really disarms.

// File: rtl/bus_turnaround_timer.sv
module bus_turnaround_timer #(
  parameter int LIMIT_BT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic eop_seen,
  input  logic line_idle,
  input  logic follow_expected,
  output logic timeout_err
);
  localparam int CW = $clog2(LIMIT_BT + 2);
  localparam logic [CW-1:0] LAST = CW'(LIMIT_BT);

  logic          armed;
  logic [CW-1:0] cnt;
  logic          arm_now, cancel, expire;

  assign arm_now = eop_seen && follow_expected;
  assign cancel  = armed && !line_idle;
  assign expire  = armed && line_idle && bit_tick && (cnt == LAST) && !eop_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      cnt         <= '0;
      timeout_err <= 1'b0;
    end else begin
      timeout_err <= expire;
      if (eop_seen) begin
        armed <= arm_now;
        cnt   <= '0;
      end else if (cancel || expire) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (armed && bit_tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_turnaround_timer_chk.sv
module bus_turnaround_timer_chk (
  input logic clk,
  input logic rst,
  input logic bit_tick,
  input logic eop_seen,
  input logic line_idle,
  input logic follow_expected,
  input logic timeout_err
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk)
    if (rst_q) a_r1_reset_quiet: assert (!timeout_err);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);

  a_r7_on_tick: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> $past(bit_tick));

  a_r4_idle_required: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> $past(line_idle));

  a_r6_no_eop_same_edge: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> !$past(eop_seen));

  a_r5_no_spurious_after_plain_eop: assert property (@(posedge clk) disable iff (rst)
    (eop_seen && !follow_expected) |=> !timeout_err);
endmodule

bind bus_turnaround_timer bus_turnaround_timer_chk u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .eop_seen(eop_seen),
  .line_idle(line_idle), .follow_expected(follow_expected),
  .timeout_err(timeout_err)
);

// File: tb/test_bus_turnaround_timer.sv
module test_bus_turnaround_timer;
  logic clk = 0, rst = 1, bit_tick = 0, eop_seen = 0, line_idle = 1, follow_expected = 0;
  logic timeout_err;
  int checks = 0, failures = 0, pulses = 0, cycles = 0;
  string req = "R1";

  bus_turnaround_timer i_bus_turnaround_timer (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .eop_seen(eop_seen),
    .line_idle(line_idle), .follow_expected(follow_expected),
    .timeout_err(timeout_err));

  always #10 clk = ~clk;

  // behavioural reference: armed flag plus tick counter as integers
  bit m_armed = 0; int m_ticks = 0; bit m_to = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin m_armed = 0; m_ticks = 0; m_to = 0; end
    else begin
      m_to = 0;
      if (eop_seen) begin m_armed = follow_expected; m_ticks = 0; end
      else if (m_armed && !line_idle) begin m_armed = 0; m_ticks = 0; end
      else if (m_armed && bit_tick) begin
        m_ticks++;
        if (m_ticks > 16) begin m_to = 1; m_armed = 0; m_ticks = 0; end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (timeout_err !== m_to) begin
      failures++;
      $display("FAIL %s cycle %0d timeout_err actual=%b expected=%b", req, cycles, timeout_err, m_to);
    end
    if (timeout_err === 1'b1) pulses++;
  end

  task automatic clk1(); @(negedge clk); endtask
  task automatic eop(bit fol);
    eop_seen = 1; follow_expected = fol; clk1(); eop_seen = 0; follow_expected = 0;
  endtask
  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1; clk1(); bit_tick = 0;
      for (int g = 0; g < gap; g++) clk1();
    end
  endtask
  task automatic expect_pulses(int exp, string r);
    clk1(); clk1(); clk1();
    checks++;
    if (pulses != exp) begin
      failures++;
      $display("FAIL %s pulse count actual=%0d expected=%0d", r, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    repeat (3) clk1();
    req = "R1"; checks++;
    if (timeout_err !== 1'b0) begin failures++; $display("FAIL R1 reset actual=%b expected=0", timeout_err); end
    rst = 0; clk1(); pulses = 0;

    req = "R2"; eop(1); ticks(17, 0); expect_pulses(1, "R2");
    req = "R3"; eop(1); ticks(17, 0); ticks(20, 0); expect_pulses(1, "R3");
    req = "R4"; eop(1); ticks(16, 0); line_idle = 0; clk1(); line_idle = 1; ticks(20, 0); expect_pulses(0, "R4");
    req = "R4"; eop(1); ticks(16, 0); line_idle = 0; bit_tick = 1; clk1(); bit_tick = 0; line_idle = 1;
    ticks(20, 0); expect_pulses(0, "R4");
    req = "R5"; eop(0); ticks(30, 0); expect_pulses(0, "R5");
    req = "R6"; eop(1); ticks(10, 0); eop(1); ticks(16, 0); expect_pulses(0, "R6");
    ticks(1, 0); expect_pulses(1, "R6");
    req = "R7"; eop(1); ticks(16, 3); expect_pulses(0, "R7");
    ticks(1, 2); expect_pulses(1, "R7");
    req = "R8"; eop(1); ticks(10, 0); rst = 1; clk1(); rst = 0; ticks(25, 0); expect_pulses(0, "R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule